// File: doc/BRIEF.md
# Discharge Rate Capacity Compensator

This datapath block trims the available-charge figure of a battery gauge to account for high discharge rates. Each cycle that an input strobe is high, it takes a one-byte compensation setting, the averaged discharge current, the learned full capacity and the nominal available charge. It then produces a compensated charge value on the following clock edge.

The rate term is a 6-bit gain multiplied by the part of the current that lies above a threshold, scaled down by 256. The threshold is zero or a power-of-two fraction of the learned capacity. When an end-of-discharge event arrives with a strobe, the block stores the rate term of that cycle as a baseline. Later results subtract only the part of the rate term that lies above the stored baseline, so the correction tracks the capacity as it is learned. An override input replaces the setting byte with a fixed default.

Top module: `rate_comp_top`

## Requirements
- R1: The setting byte carries the gain in bits [7:2] and the threshold select code in bits [1:0].
- R2: The select code sets the threshold as follows: 0 gives zero, 1 gives capacity shifted right by 1, 2 gives capacity shifted right by 2, and 3 gives capacity shifted right by 3.
- R3: The rate term equals gain × (current − threshold) / 256, with the division truncated toward zero.
- R4: When the current is at or below the threshold, the rate term is zero and the result equals the nominal charge.
- R5: When the rate term exceeds the baseline, the result is nominal − (term − baseline). Otherwise the result is nominal.
- R6: The subtraction saturates at zero, so the result never exceeds the nominal charge and never wraps.
- R7: A strobe with the end-of-discharge pulse high loads that cycle's rate term into the baseline. The loaded value first affects the next strobe. A pulse without a strobe has no effect.
- R8: When the override input is high, the setting byte is ignored and the value 0x42 is used instead (gain 16, select code 2).
- R9: The result and its valid flag appear one clock after a strobe. Without a strobe, the valid flag is low and the result holds its last value.
- R10: Reset clears the valid flag, the result and the baseline. Reset is asserted asynchronously and released two clocks later, in step with the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input strobe |
| cfg_byte | input | 8 | Gain [7:2] and threshold select [1:0] |
| cfg_fixed | input | 1 | Use the built-in setting 0x42 |
| avg_current | input | 16 | Averaged discharge current |
| learned_cap | input | 16 | Learned full capacity |
| nominal_charge | input | 16 | Uncompensated available charge |
| eod_pulse | input | 1 | End-of-discharge event, loads the baseline |
| out_valid | output | 1 | Result valid |
| comp_charge | output | 16 | Compensated available charge |

## Verification
Every result is due on the first rising edge after its strobe. A baseline loaded at a strobe first changes the result of the next strobe, not the one that loaded it. The bench drives each stimulus on a falling edge and advances a behavioural model at the rising edge. It compares out_valid and comp_charge one nanosecond after that edge, on every clock, including idle clocks where the result must hold. After reset is released, the bench waits several clocks so that the two-stage release has finished before the first strobe.

// File: rtl/rate_comp_pkg.sv
package rate_comp_pkg;
  localparam int DATA_W    = 16;
  localparam int GAIN_W    = 6;
  localparam int SEL_W     = 2;
  localparam int CFG_W     = GAIN_W + SEL_W;
  localparam int FRAC_SH   = 8;
  localparam logic [CFG_W-1:0] FIXED_CFG = 8'h42;

  typedef struct packed {
    logic [GAIN_W-1:0] gain;
    logic [SEL_W-1:0]  sel;
  } rate_cfg_t;
endpackage

// File: rtl/rate_comp_rst_sync.sv
module rate_comp_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/rate_comp_thresh.sv
module rate_comp_thresh
  import rate_comp_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic [CFG_W-1:0]  cfg_byte,
  input  logic              cfg_fixed,
  input  logic [DW-1:0]     learned_cap,
  output logic [GAIN_W-1:0] gain,
  output logic [DW-1:0]     threshold
);
  localparam int NSEL = 1 << SEL_W;

  rate_cfg_t       cfg_eff;
  logic [DW-1:0]   cand [NSEL];

  always_comb begin
    cfg_eff = cfg_fixed ? rate_cfg_t'(FIXED_CFG) : rate_cfg_t'(cfg_byte);
  end

  genvar g;
  generate
    for (g = 0; g < NSEL; g++) begin : g_cand
      if (g == 0) begin : g_zero
        assign cand[g] = '0;
      end else begin : g_shift
        assign cand[g] = learned_cap >> g;
      end
    end
  endgenerate

  assign gain      = cfg_eff.gain;
  assign threshold = cand[cfg_eff.sel];

  AST_THR_BOUND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    threshold <= learned_cap); // R2
  AST_FIXED_GAIN: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_fixed |-> (gain == GAIN_W'(16) && threshold == (learned_cap >> 2))); // R8
endmodule

// File: rtl/rate_comp_term.sv
module rate_comp_term
  import rate_comp_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic              clk,
  input  logic              rst_sync_n,
  input  logic [GAIN_W-1:0] gain,
  input  logic [DW-1:0]     threshold,
  input  logic [DW-1:0]     avg_current,
  output logic [DW-1:0]     term
);
  localparam int PW = DW + GAIN_W;

  logic [DW-1:0] excess;
  logic [PW-1:0] prod;

  always_comb begin
    excess = (avg_current > threshold) ? (avg_current - threshold) : '0;
    prod   = PW'(gain) * PW'(excess);
  end

  assign term = DW'(prod >> FRAC_SH);

  AST_ZERO_BELOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (avg_current <= threshold) |-> (term == '0)); // R4
  AST_TERM_BOUND: assert property (@(posedge clk) disable iff (!rst_sync_n)
    term <= avg_current); // R3
endmodule

// File: rtl/rate_comp_base.sv
module rate_comp_base
  import rate_comp_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rst_sync_n,
  input  logic          load_en,
  input  logic [DW-1:0] term,
  output logic [DW-1:0] base
);
  logic [DW-1:0] base_q;
  logic [DW-1:0] base_d;

  always_comb begin
    base_d = base_q;
    if (load_en) base_d = term;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          base_q <= '0;
    else if (!rst_sync_n) base_q <= '0;
    else                 base_q <= base_d;
  end

  assign base = base_q;

  AST_BASE_LOAD: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load_en |=> (base == $past(term))); // R7
  AST_BASE_KEEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !load_en |=> $stable(base)); // R7
endmodule

// File: rtl/rate_comp_top.sv
module rate_comp_top
  import rate_comp_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [CFG_W-1:0] cfg_byte,
  input  logic             cfg_fixed,
  input  logic [DW-1:0]    avg_current,
  input  logic [DW-1:0]    learned_cap,
  input  logic [DW-1:0]    nominal_charge,
  input  logic             eod_pulse,
  output logic             out_valid,
  output logic [DW-1:0]    comp_charge
);
  logic              rst_sync_n;
  logic [GAIN_W-1:0] gain;
  logic [DW-1:0]     threshold;
  logic [DW-1:0]     term;
  logic [DW-1:0]     base;
  logic [DW-1:0]     diff;
  logic [DW-1:0]     res_d;
  logic [DW-1:0]     res_q;
  logic              vld_q;
  logic              load_en;

  rate_comp_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  rate_comp_thresh #(.DW(DW)) u_thr (
    .clk(clk), .rst_sync_n(rst_sync_n), .cfg_byte(cfg_byte),
    .cfg_fixed(cfg_fixed), .learned_cap(learned_cap),
    .gain(gain), .threshold(threshold));

  rate_comp_term #(.DW(DW)) u_term (
    .clk(clk), .rst_sync_n(rst_sync_n), .gain(gain),
    .threshold(threshold), .avg_current(avg_current), .term(term));

  assign load_en = in_valid & eod_pulse;

  rate_comp_base #(.DW(DW)) u_base (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n),
    .load_en(load_en), .term(term), .base(base));

  always_comb begin
    diff  = '0;
    res_d = res_q;
    if (in_valid) begin
      if (term > base) begin
        diff  = term - base;
        res_d = (nominal_charge > diff) ? (nominal_charge - diff) : '0;
      end else begin
        res_d = nominal_charge;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else if (!rst_sync_n) begin
      vld_q <= 1'b0;
      res_q <= '0;
    end else begin
      vld_q <= in_valid;
      if (in_valid) res_q <= res_d;
    end
  end

  assign out_valid   = vld_q;
  assign comp_charge = res_q;

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> out_valid); // R9
  AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !in_valid |=> (!out_valid && $stable(comp_charge))); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_sync_n)
    in_valid |=> (comp_charge <= $past(nominal_charge))); // R6
  AST_NO_TRIM: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (in_valid && term <= base) |=> (comp_charge == $past(nominal_charge))); // R5
endmodule

// File: tb/sim_rate_comp_top.sv
module sim_rate_comp_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid;
  logic [7:0]  cfg_byte;
  logic        cfg_fixed;
  logic [15:0] avg_current;
  logic [15:0] learned_cap;
  logic [15:0] nominal_charge;
  logic        eod_pulse;
  logic        out_valid;
  logic [15:0] comp_charge;

  int checks = 0;
  int errors = 0;
  int m_base = 0;
  int m_hold = 0;

  always #2 clk = ~clk;

  rate_comp_top u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cfg_byte(cfg_byte),
    .cfg_fixed(cfg_fixed), .avg_current(avg_current), .learned_cap(learned_cap),
    .nominal_charge(nominal_charge), .eod_pulse(eod_pulse),
    .out_valid(out_valid), .comp_charge(comp_charge));

  function automatic int ref_term(int cfg, bit fx, int cur, int cap);
    int g, s, t, ex;
    if (fx) cfg = 'h42;
    g  = (cfg >> 2) & 63;
    s  = cfg & 3;
    t  = (s == 0) ? 0 : (cap >> s);
    ex = (cur > t) ? cur - t : 0;
    return (g * ex) / 256;
  endfunction

  task automatic check(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step(bit v, int cfg, bit fx, int cur, int cap, int nom,
                      bit e, string tag);
    int t, d, exp;
    @(negedge clk);
    in_valid = v; cfg_byte = 8'(cfg); cfg_fixed = fx;
    avg_current = 16'(cur); learned_cap = 16'(cap);
    nominal_charge = 16'(nom); eod_pulse = e;
    @(posedge clk);
    exp = m_hold;
    if (v) begin
      t = ref_term(cfg, fx, cur, cap);
      if (t > m_base) begin
        d = t - m_base;
        exp = (nom > d) ? nom - d : 0;
      end else exp = nom;
      if (e) m_base = t;
      m_hold = exp;
    end
    #1;
    check(out_valid == v, {tag, " valid"}, int'(out_valid), int'(v));
    check(int'(comp_charge) == exp, tag, int'(comp_charge), exp);
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; in_valid = 0; cfg_byte = 0; cfg_fixed = 0;
    avg_current = 0; learned_cap = 0; nominal_charge = 0; eod_pulse = 0;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R10 reset valid", int'(out_valid), 0);
    check(comp_charge == 16'd0, "R10 reset data", int'(comp_charge), 0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // R1 gain in bits [7:2]: 32*1000/256=125
    step(1, 'h80, 0, 1000, 4000, 5000, 0, "R1 gain32");
    step(1, 'h04, 0, 2560, 4000, 5000, 0, "R1 gain1");
    // R2 each select code, cap 4000, cur 3000, gain 16
    step(1, 'h40, 0, 3000, 4000, 9000, 0, "R2 sel0");
    step(1, 'h41, 0, 3000, 4000, 9000, 0, "R2 sel1");
    step(1, 'h42, 0, 3000, 4000, 9000, 0, "R2 sel2");
    step(1, 'h43, 0, 3000, 4000, 9000, 0, "R2 sel3");
    // R3 truncation: 63*5/256 -> 1, 63*4/256 -> 0
    step(1, 'hFC, 0, 5, 0, 100, 0, "R3 trunc1");
    step(1, 'hFC, 0, 4, 0, 100, 0, "R3 trunc0");
    // R4 current below or at threshold
    step(1, 'hFD, 0, 2000, 4000, 777, 0, "R4 at thr");
    step(1, 'hFD, 0, 100, 4000, 777, 0, "R4 below");
    // R6 saturation
    step(1, 'hFC, 0, 65535, 0, 10, 0, "R6 sat");
    // R9 idle cycles hold
    step(0, 'hFC, 0, 65535, 0, 10, 1, "R9 idle");
    step(0, 0, 0, 0, 0, 0, 0, "R9 idle2");
    // R7 load baseline (term 125) then smaller and larger terms
    step(1, 'h80, 0, 1000, 0, 5000, 1, "R7 load");
    step(1, 'h80, 0, 800, 0, 5000, 0, "R5 under base");
    step(1, 'h80, 0, 2000, 0, 5000, 0, "R5 over base");
    step(0, 'h80, 0, 0, 0, 0, 1, "R7 pulse no strobe");
    step(1, 'h80, 0, 1000, 0, 5000, 0, "R7 base kept");
    step(1, 0, 0, 0, 0, 5000, 1, "R7 clear");
    // R8 override ignores byte
    step(1, 'hFF, 1, 3000, 4000, 5000, 0, "R8 fixed ff");
    step(1, 'h00, 1, 3000, 4000, 5000, 0, "R8 fixed 00");
    for (int i = 0; i < 300; i++) begin
      step(($urandom % 4) != 0, $urandom % 256, ($urandom % 5) == 0,
           $urandom % 65536, $urandom % 65536, $urandom % 65536,
           ($urandom % 6) == 0, "R5 random");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule